// File: doc/BRIEF.md
# Shared Memory Arbiter with Posted Host Writes

This block lets two masters share one internal memory bus. The first is an external host on an asynchronous card-style strobe interface: chip enable, output enable and write enable, all active low, plus an active-low WAIT output that stretches the host cycle. The second is an embedded processor on a level request / one-cycle acknowledge port. The bus reaches two regions, flash and SRAM. The top address bit selects the region, and each region has its own wait-state count of 0 to 3 bus clocks.

Host writes go into a one-entry posted-write buffer, so the host cycle ends at once while the bus is still busy. The buffer is written to memory between processor accesses. A host read has to reach the bus before it can complete, and it holds the host on WAIT until its data is in the output register. Grants alternate between the host side and the processor, and a posted write always goes ahead of a host read. A host read therefore waits out a fixed interleaving: first the posted write drains, then one more processor access may run, and only then is the read granted.

Top module: `shmem_arbiter`

## Requirements
- R1: The host strobes pass through two-flop synchronizers. A host request starts on the third rising clock edge after the pins go active. A read is chip enable and output enable low with write enable high. A write is chip enable and write enable low. An idle bus grants a read on that same edge, and `mem_req` is seen high in the following cycle.
- R2: A memory access holds `mem_req` high for exactly ws+1 consecutive cycles with a stable address. ws is `flash_ws` when address bit AW-1 is 1 and `sram_ws` when it is 0. `mem_req` drops for at least one cycle between accesses.
- R3: A host write that finds the posted-write buffer empty is accepted without WAIT going low. Its data reaches memory later.
- R4: A posted write is written only after the processor access in progress has finished. It always goes onto the bus before a pending host read, so a host read returns the data of an earlier host write to the same address.
- R5: When the bus is free, a waiting processor request wins if the last grant went to the host side (posted write or read). After a processor access, a waiting host operation wins.
- R6: A host read that is not granted with zero wait states on its detection edge drives `host_wait_n` low from that edge. `host_wait_n` returns high on the edge where the read data is loaded into `host_rdata`, so the data is valid when WAIT releases.
- R7: With zero wait states and no contention, a host read completes with `host_wait_n` high throughout, and its data is valid one cycle after the grant.
- R8: `host_rdata_oe` is high exactly while `host_ce_n` and `host_oe_n` are both low. It follows the pins with no clock delay.
- R9: A host write that arrives while the buffer is still full drives `host_wait_n` low until the buffer has drained. The write is then accepted from the pins and WAIT is released.
- R10: The processor sees `cpu_ack` as a single-cycle pulse at the end of its access, with read data valid on `cpu_rdata` in that cycle.
- R11: After reset, `host_wait_n` is 1, `mem_req` is 0, `cpu_ack` is 0 and the posted-write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| host_addr | input | AW | Host address, held stable through the cycle |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered host read data |
| host_rdata_oe | output | 1 | Tri-state enable for the host data pads |
| host_wait_n | output | 1 | Host WAIT, active low |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | One-cycle acknowledge |
| cpu_rdata | output | DW | Processor read data, valid with ack |
| flash_ws | input | WS_BITS | Flash wait-state count |
| sram_ws | input | WS_BITS | SRAM wait-state count |
| mem_req | output | 1 | Memory bus access active |
| mem_we | output | 1 | Memory bus write |
| mem_addr | output | AW | Memory bus address |
| mem_wdata | output | DW | Memory bus write data |
| mem_rdata | input | DW | Memory bus read data, valid in the last access cycle |

## Verification
The bench builds the block with AW=6, DW=16 and WS_BITS=2. A 64-word shadow model therefore covers the whole memory, random addresses hit the same words often, and every wait-state count from 0 to 3 appears in both regions. Splitting each region into a processor half and a host half keeps the expected data exact while host and processor traffic run concurrently. The small wait-state range also makes the cycle-exact directed cases reachable: the held read behind a draining posted write, and the held second write.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_PW   = 2'd2,
    SRC_RD   = 2'd3
  } src_e;
endpackage

// File: rtl/shm_strobe_sync.sv
module shm_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl_n
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], pin_n[b]};
    end
    assign lvl_n[b] = chain[LAST];
  end
endmodule

// File: rtl/shm_grant.sv
module shm_grant
  import shm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  input  logic last_host,
  input  logic cpu_cand,
  input  logic pw_cand,
  input  logic rd_cand,
  output src_e grant
);
  always_comb begin
    grant = SRC_NONE;
    if (bus_idle) begin
      if (last_host && cpu_cand) grant = SRC_CPU;
      else if (pw_cand)          grant = SRC_PW;
      else if (rd_cand)          grant = SRC_RD;
      else if (cpu_cand)         grant = SRC_CPU;
    end
  end

  // R4: a host read never passes a buffered write
  assert_drain_first_R4: assert property (@(posedge clk) disable iff (rst)
    (grant == SRC_RD) |-> !pw_cand);
endmodule

// File: rtl/shm_bus_timer.sv
module shm_bus_timer #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int WS_BITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_we,
  input  logic [AW-1:0]      start_addr,
  input  logic [DW-1:0]      start_wdata,
  input  logic [WS_BITS-1:0] flash_ws,
  input  logic [WS_BITS-1:0] sram_ws,
  output logic               busy,
  output logic               done,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata
);
  localparam int REGION_BIT = AW - 1;

  logic [WS_BITS-1:0] cnt;
  logic [WS_BITS-1:0] ws_sel;

  assign ws_sel = start_addr[REGION_BIT] ? flash_ws : sram_ws;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= ws_sel;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !busy) begin
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end
  end

  // R2: an access in flight keeps its address and stays on the bus
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shm_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int WS_BITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_ce_n,
  input  logic               host_oe_n,
  input  logic               host_we_n,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_rdata_oe,
  output logic               host_wait_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic               cpu_ack,
  output logic [DW-1:0]      cpu_rdata,
  input  logic [WS_BITS-1:0] flash_ws,
  input  logic [WS_BITS-1:0] sram_ws,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata
);
  localparam int REGION_BIT = AW - 1;
  localparam int I_CE = 0;
  localparam int I_OE = 1;
  localparam int I_WE = 2;

  // strobe synchronization and request edges
  logic [2:0] strobe_s;
  shm_strobe_sync #(.N(3), .STAGES(2)) i_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n ({host_we_n, host_oe_n, host_ce_n}),
    .lvl_n (strobe_s)
  );

  logic rd_act, wr_act, rd_act_q, wr_act_q, rd_evt, wr_evt;
  assign rd_act = ~strobe_s[I_CE] & ~strobe_s[I_OE] & strobe_s[I_WE];
  assign wr_act = ~strobe_s[I_CE] & ~strobe_s[I_WE];
  assign rd_evt = rd_act & ~rd_act_q;
  assign wr_evt = wr_act & ~wr_act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  // arbitration
  logic pw_valid, wr_pend, rd_pend, rd_wait, last_host;
  logic [AW-1:0] pw_addr;
  logic [DW-1:0] pw_data;
  src_e grant, cur_src;
  logic bus_busy, bus_done;
  logic cpu_cand, rd_cand, pw_load;
  logic [WS_BITS-1:0] rd_ws;

  assign cpu_cand = cpu_req & ~cpu_ack;
  assign rd_cand  = rd_pend | rd_evt;
  assign pw_load  = ~pw_valid & (wr_evt | wr_pend);
  assign rd_ws    = host_addr[REGION_BIT] ? flash_ws : sram_ws;

  shm_grant i_grant (
    .clk       (clk),
    .rst       (rst),
    .bus_idle  (~bus_busy),
    .last_host (last_host),
    .cpu_cand  (cpu_cand),
    .pw_cand   (pw_valid),
    .rd_cand   (rd_cand),
    .grant     (grant)
  );

  logic          st_we;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_wdata;

  always_comb begin
    st_we    = 1'b0;
    st_addr  = host_addr;
    st_wdata = pw_data;
    case (grant)
      SRC_CPU: begin
        st_we    = cpu_we;
        st_addr  = cpu_addr;
        st_wdata = cpu_wdata;
      end
      SRC_PW: begin
        st_we   = 1'b1;
        st_addr = pw_addr;
      end
      default: ;
    endcase
  end

  shm_bus_timer #(.AW(AW), .DW(DW), .WS_BITS(WS_BITS)) i_timer (
    .clk         (clk),
    .rst         (rst),
    .start       (grant != SRC_NONE),
    .start_we    (st_we),
    .start_addr  (st_addr),
    .start_wdata (st_wdata),
    .flash_ws    (flash_ws),
    .sram_ws     (sram_ws),
    .busy        (bus_busy),
    .done        (bus_done),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );
  assign mem_req = bus_busy;

  // transaction state
  always_ff @(posedge clk) begin
    if (rst) begin
      pw_valid   <= 1'b0;
      wr_pend    <= 1'b0;
      rd_pend    <= 1'b0;
      rd_wait    <= 1'b0;
      last_host  <= 1'b0;
      cur_src    <= SRC_NONE;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      if (wr_evt && pw_valid) wr_pend <= 1'b1;
      if (pw_load) begin
        pw_valid <= 1'b1;
        wr_pend  <= 1'b0;
      end
      if (rd_evt && grant != SRC_RD) rd_pend <= 1'b1;
      if (rd_evt && !(grant == SRC_RD && rd_ws == '0)) rd_wait <= 1'b1;
      if (grant != SRC_NONE) begin
        cur_src   <= grant;
        last_host <= (grant != SRC_CPU);
      end
      if (grant == SRC_RD) rd_pend <= 1'b0;
      if (bus_done) begin
        case (cur_src)
          SRC_CPU: begin
            cpu_ack   <= 1'b1;
            cpu_rdata <= mem_rdata;
          end
          SRC_PW: pw_valid <= 1'b0;
          SRC_RD: begin
            host_rdata <= mem_rdata;
            rd_wait    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pw_load) begin
      pw_addr <= host_addr;
      pw_data <= host_wdata;
    end
  end

  assign host_wait_n   = ~(rd_wait | wr_pend);
  assign host_rdata_oe = ~host_ce_n & ~host_oe_n;

  // R10: acknowledge lasts a single cycle
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  // R5: processor is served after a host-side grant
  assert_turn_R5: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && last_host && cpu_cand) |=> (bus_busy && cur_src == SRC_CPU));

  // R6: WAIT on a read ends only with the read's data capture
  assert_wait_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_wait) |-> $past(bus_done && cur_src == SRC_RD));

  // R9: a held write enters the buffer as soon as it empties
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && !pw_valid) |=> (pw_valid && !wr_pend));
endmodule

// File: tb/test_shmem_arbiter.sv
module test_shmem_arbiter;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WS_BITS = 2;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_rdata_oe, host_wait_n;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic [WS_BITS-1:0] fw = '0, sw = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  shmem_arbiter #(.AW(AW), .DW(DW), .WS_BITS(WS_BITS)) i_shmem_arbiter (
    .clk(clk), .rst(rst),
    .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .host_wait_n(host_wait_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .flash_ws(fw), .sram_ws(sw),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 16'h0101) ^ 16'h5a5a;
  endfunction

  function automatic int exp_ws(input logic region);
    return region ? int'(fw) : int'(sw);
  endfunction

  // memory model
  logic [DW-1:0] mem_model [WORDS];
  assign mem_rdata = mem_model[mem_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem_model[i] <= init_val(i);
    end else if (mem_req && mem_we) begin
      mem_model[mem_addr] <= mem_wdata;
    end
  end

  logic [DW-1:0] shadow [WORDS];
  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor: run lengths (R2) and grant order log
  int run = 0;
  logic run_region = 1'b0;
  bit log_en = 1'b0;
  int log_n = 0;
  logic [AW-1:0] log_addr [8];
  logic log_we [8];
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        if (run == 0) begin
          run_region = mem_addr[AW-1];
          if (log_en && log_n < 8) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n] = mem_we;
            log_n++;
          end
        end
        run++;
      end else if (run > 0) begin
        chk("R2 access length", run, exp_ws(run_region) + 1);
        run = 0;
      end
    end
  end

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int idle, output bit waited);
    host_addr = a; host_wdata = d; host_ce_n = 1'b0; host_we_n = 1'b0;
    waited = 1'b0;
    repeat (4) @(negedge clk);
    while (!host_wait_n) begin
      waited = 1'b1;
      @(negedge clk);
    end
    host_we_n = 1'b1; host_ce_n = 1'b1;
    repeat (idle) @(negedge clk);
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] q,
                           output bit waited);
    host_addr = a; host_ce_n = 1'b0; host_oe_n = 1'b0;
    waited = 1'b0;
    repeat (4) @(negedge clk);
    while (!host_wait_n) begin
      waited = 1'b1;
      @(negedge clk);
    end
    q = host_rdata;
    host_oe_n = 1'b1; host_ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cpu_access(input bit we, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, output logic [DW-1:0] q);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_ack);
    q = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!finished && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=finish", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    bit w1, w2;
    logic [AW-1:0] ha;
    void'($urandom(32'h0051_7e3a));
    for (int i = 0; i < WORDS; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 wait_n", host_wait_n, 1);
    chk("R11 mem_req", mem_req, 0);
    chk("R11 cpu_ack", cpu_ack, 0);
    chk("R11 rdata_oe", host_rdata_oe, 0);

    // R8 output enable follows pins
    host_ce_n = 1'b1; host_oe_n = 1'b0; #1;
    chk("R8 oe without ce", host_rdata_oe, 0);
    host_ce_n = 1'b0; host_oe_n = 1'b1; #1;
    chk("R8 ce without oe", host_rdata_oe, 0);
    host_ce_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R7: zero wait states, no contention, sram host word 0x12
    fw = 2'd0; sw = 2'd0;
    host_addr = 6'h12; host_ce_n = 1'b0; host_oe_n = 1'b0; #1;
    chk("R8 ce and oe low", host_rdata_oe, 1);
    @(negedge clk); chk("R7 wait n1", host_wait_n, 1); chk("R1 no req n1", mem_req, 0);
    @(negedge clk); chk("R7 wait n2", host_wait_n, 1); chk("R1 no req n2", mem_req, 0);
    @(negedge clk); chk("R7 wait n3", host_wait_n, 1); chk("R1 req n3", mem_req, 1);
    @(negedge clk); chk("R7 wait n4", host_wait_n, 1);
    chk("R7 data", host_rdata, shadow[6'h12]);
    host_oe_n = 1'b1; #1;
    chk("R8 released", host_rdata_oe, 0);
    host_ce_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: sram ws 2, read held on WAIT until data capture
    sw = 2'd2;
    host_addr = 6'h15; host_ce_n = 1'b0; host_oe_n = 1'b0;
    repeat (3) @(negedge clk); chk("R6 wait low n3", host_wait_n, 0);
    @(negedge clk); chk("R6 wait low n4", host_wait_n, 0);
    @(negedge clk); chk("R6 wait low n5", host_wait_n, 0);
    @(negedge clk); chk("R6 wait released n6", host_wait_n, 1);
    chk("R6 data at release", host_rdata, shadow[6'h15]);
    host_oe_n = 1'b1; host_ce_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 + R10: uncontended posted write, processor ack pulse
    host_write(6'h17, 16'hbeef, 2, w1); shadow[6'h17] = 16'hbeef;
    chk("R3 no wait on post", w1, 0);
    repeat (6) @(negedge clk);
    chk("R3 write reached memory", mem_model[6'h17], 16'hbeef);
    cpu_access(1'b1, 6'h03, 16'h1234, q); shadow[6'h03] = 16'h1234;
    @(negedge clk); chk("R10 ack one cycle", cpu_ack, 0);
    cpu_access(1'b0, 6'h03, 16'h0, q);
    chk("R10 cpu read data", q, 16'h1234);
    repeat (4) @(negedge clk);

    // R4 / R5: cpu flash read, host flash write then read, second cpu access
    fw = 2'd3; sw = 2'd1;
    log_n = 0; log_en = 1'b1;
    fork
      begin
        logic [DW-1:0] cq;
        cpu_access(1'b0, 6'h21, 16'h0, cq);
        cpu_access(1'b1, 6'h22, 16'h7777, cq);
      end
      begin
        bit hw;
        host_write(6'h31, 16'hc0de, 2, hw);
        host_read(6'h31, q, w2);
      end
    join
    log_en = 1'b0;
    shadow[6'h31] = 16'hc0de; shadow[6'h22] = 16'h7777;
    chk("R4 read sees posted data", q, 16'hc0de);
    chk("R6 held read waited", w2, 1);
    chk("R5 grant count", log_n, 4);
    chk("R5 first cpu read", {log_we[0], log_addr[0]}, {1'b0, 6'h21});
    chk("R4 drain after cpu", {log_we[1], log_addr[1]}, {1'b1, 6'h31});
    chk("R5 cpu before read", {log_we[2], log_addr[2]}, {1'b1, 6'h22});
    chk("R5 read last", {log_we[3], log_addr[3]}, {1'b0, 6'h31});
    repeat (4) @(negedge clk);

    // R9: second write while buffer full
    fork
      begin
        logic [DW-1:0] cq;
        cpu_access(1'b0, 6'h24, 16'h0, cq);
      end
      begin
        host_write(6'h33, 16'h1111, 2, w1);
        host_write(6'h34, 16'h2222, 2, w2);
      end
    join
    shadow[6'h33] = 16'h1111; shadow[6'h34] = 16'h2222;
    chk("R3 first write not held", w1, 0);
    chk("R9 second write held", w2, 1);
    host_read(6'h33, q, w1); chk("R9 first data", q, 16'h1111);
    host_read(6'h34, q, w1); chk("R9 second data", q, 16'h2222);

    // random mixed traffic
    for (int chunk = 0; chunk < 4; chunk++) begin
      repeat (10) @(negedge clk);
      fw = WS_BITS'($urandom % 4); sw = WS_BITS'($urandom % 4);
      fork
        for (int k = 0; k < 25; k++) begin
          logic [AW-1:0] ca;
          logic [DW-1:0] cd, cq;
          ca = {1'($urandom % 2), 1'b0, 4'($urandom % 16)};
          cd = DW'($urandom);
          if ($urandom % 2 == 1) begin
            cpu_access(1'b1, ca, cd, cq);
            shadow[ca] = cd;
          end else begin
            cpu_access(1'b0, ca, cd, cq);
            chk("R10 cpu random read", cq, shadow[ca]);
          end
          repeat ($urandom % 3) @(negedge clk);
        end
        for (int k = 0; k < 20; k++) begin
          logic [DW-1:0] hd, hq;
          bit hw;
          ha = {1'($urandom % 2), 1'b1, 4'($urandom % 16)};
          hd = DW'($urandom);
          if ($urandom % 2 == 1) begin
            host_write(ha, hd, 2 + $urandom % 2, hw);
            shadow[ha] = hd;
          end else begin
            host_read(ha, hq, hw);
            chk("R4 host random read", hq, shadow[ha]);
          end
        end
      join
    end
    repeat (10) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule